// File: doc/BRIEF.md
# Three-Wire Serial Word Loader

This block takes a data line, a clock line and an enable line from a slow external controller and loads a 19-bit control word for a frequency synthesizer. All three lines are first brought into the system clock domain through synchronizer stages. Their edges are then detected on the synchronized copies. While enable is high, each falling edge of the serial clock shifts one data bit into a 19-bit register. When enable falls, the word is copied into the output latches only if the enable-high window contained exactly nineteen clock falling edges. Any other count leaves the latched values as they were.

The word carries four port bits first, followed by a 15-bit divider scaling factor sent most significant bit first. A static mode input selects three-wire operation. In that mode the block forces the high charge-pump current select and drives the SW1 switch pin from the lock flag. When the mode input is low, the serial loader is idle, and both pins follow the values supplied by the two-wire control path. All outputs are registered.

Top module: `tw_loader_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `scale_q`, `port_q`, `pump_hi` and `sw1_on` are cleared to zero at that edge.
- R2: Bits are captured in arrival order. The first bit lands in `port_q[3]` and the fourth in `port_q[0]`. The fifth lands in `scale_q[14]` and the nineteenth in `scale_q[0]`.
- R3: Serial clock falling edges that occur while the synchronized enable is low are neither counted nor shifted.
- R4: The latches load only on a synchronized enable falling edge, and only when exactly 19 clock falling edges were counted in that enable-high window. A window with 18 edges is rejected.
- R5: The edge counter saturates at 20, so a window with 20 or more clock falling edges is rejected.
- R6: A rejected window leaves `scale_q` and `port_q` unchanged.
- R7: The edge counter is cleared at every synchronized enable rising edge, so a rejected window never contributes edges to the next one.
- R8: `pump_hi` is 1 one clock after a cycle with `mode_3w` high. Otherwise it follows `alt_pump_hi` with one clock of delay.
- R9: `sw1_on` (1 = switch on, low impedance) follows `lock_in` with one clock of delay when `mode_3w` is high. Otherwise it follows `alt_sw1` with one clock of delay.
- R10: While `mode_3w` is low, serial traffic does not change `scale_q` or `port_q`.
- R11: A serial line change applied before rising clock edge n acts at edge n+SYNC_STAGES. A valid load therefore appears on the outputs SYNC_STAGES+1 clocks after the enable line falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_3w | input | 1 | Selects three-wire operation |
| ser_dat | input | 1 | Serial data line (asynchronous) |
| ser_clk | input | 1 | Serial clock line (asynchronous) |
| ser_en | input | 1 | Serial enable line (asynchronous) |
| lock_in | input | 1 | Loop lock flag, 1 = locked |
| alt_pump_hi | input | 1 | Pump current select from the two-wire path |
| alt_sw1 | input | 1 | SW1 switch value from the two-wire path |
| scale_q | output | 15 | Latched divider scaling factor |
| port_q | output | 4 | Latched port bits, [3] is the first bit received |
| pump_hi | output | 1 | High charge-pump current select |
| sw1_on | output | 1 | SW1 pin drive, 1 = on |

## Verification
The bench sends two different 19-bit words, chosen so that a swapped port order or a reversed scaling factor shows up as a wrong value. Windows of 18, 20 and 25 clock edges separate an exact-count check from a "19 or more" or "at most 19" check. A short rejected burst followed by a valid word shows whether the counter is cleared at the enable rising edge. Clock pulses sent while enable is low, and a full word sent with the mode input low, test the two gating paths. Toggling the lock and two-wire inputs in both modes tests the pin routing.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned TW_PORT_W = 4;
  localparam int unsigned TW_SF_W   = 15;
  localparam int unsigned TW_SYNC   = 2;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync,
  output logic [W-1:0] d_prev
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) d_prev <= '0;
    else     d_prev <= stg[STAGES-1];
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int unsigned WORD_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_mode,
  input  logic              dat_s,
  input  logic              sck_s,
  input  logic              sck_d,
  input  logic              en_s,
  input  logic              en_d,
  output logic [WORD_W-1:0] word,
  output logic              en_fall,
  output logic              load
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0] cnt;
  logic en_rise, sck_fall;

  assign en_rise  = en_s & ~en_d;
  assign en_fall  = ~en_s & en_d;
  assign sck_fall = ~sck_s & sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      word <= '0;
    end else if (!enable_mode) begin
      cnt <= '0;
    end else if (en_rise) begin
      cnt <= '0;
    end else if (en_s && sck_fall) begin
      word <= {word[WORD_W-2:0], dat_s};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  assign load = enable_mode & en_fall & (cnt == CNT_FULL);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_SAT); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (en_rise && enable_mode) |=> (cnt == '0)); // R7
  AST_LOW_EN_NOCOUNT: assert property (@(posedge clk) disable iff (rst)
    (!en_s && !en_rise) |=> $stable(word)); // R3
endmodule

// File: rtl/tw_word_latch.sv
module tw_word_latch #(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned SF_W   = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [PORT_W+SF_W-1:0] word,
  output logic [SF_W-1:0]        scale_q,
  output logic [PORT_W-1:0]      port_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q <= '0;
      port_q  <= '0;
    end else if (load) begin
      port_q  <= word[PORT_W+SF_W-1:SF_W];
      scale_q <= word[SF_W-1:0];
    end
  end
endmodule

// File: rtl/tw_pin_route.sv
module tw_pin_route (
  input  logic clk,
  input  logic rst,
  input  logic mode_3w,
  input  logic lock_in,
  input  logic alt_pump_hi,
  input  logic alt_sw1,
  output logic pump_hi,
  output logic sw1_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pump_hi <= 1'b0;
      sw1_on  <= 1'b0;
    end else begin
      pump_hi <= mode_3w ? 1'b1    : alt_pump_hi;
      sw1_on  <= mode_3w ? lock_in : alt_sw1;
    end
  end
endmodule

// File: rtl/tw_loader_top.sv
module tw_loader_top #(
  parameter int unsigned PORT_W      = tw_pkg::TW_PORT_W,
  parameter int unsigned SF_W        = tw_pkg::TW_SF_W,
  parameter int unsigned SYNC_STAGES = tw_pkg::TW_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_3w,
  input  logic              ser_dat,
  input  logic              ser_clk,
  input  logic              ser_en,
  input  logic              lock_in,
  input  logic              alt_pump_hi,
  input  logic              alt_sw1,
  output logic [SF_W-1:0]   scale_q,
  output logic [PORT_W-1:0] port_q,
  output logic              pump_hi,
  output logic              sw1_on
);
  localparam int unsigned WORD_W = PORT_W + SF_W;

  logic [2:0] line_s, line_d;
  logic [WORD_W-1:0] word_w;
  logic load_w, en_fall_w;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst),
    .d_async({ser_en, ser_clk, ser_dat}),
    .d_sync(line_s), .d_prev(line_d)
  );

  tw_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst(rst), .enable_mode(mode_3w),
    .dat_s(line_s[0]), .sck_s(line_s[1]), .sck_d(line_d[1]),
    .en_s(line_s[2]), .en_d(line_d[2]),
    .word(word_w), .en_fall(en_fall_w), .load(load_w)
  );

  tw_word_latch #(.PORT_W(PORT_W), .SF_W(SF_W)) i_latch (
    .clk(clk), .rst(rst), .load(load_w), .word(word_w),
    .scale_q(scale_q), .port_q(port_q)
  );

  tw_pin_route i_route (
    .clk(clk), .rst(rst), .mode_3w(mode_3w), .lock_in(lock_in),
    .alt_pump_hi(alt_pump_hi), .alt_sw1(alt_sw1),
    .pump_hi(pump_hi), .sw1_on(sw1_on)
  );

  AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !($stable(scale_q) && $stable(port_q)) |-> $past(en_fall_w)); // R4
  AST_OFF_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mode_3w |=> ($stable(scale_q) && $stable(port_q))); // R10
  AST_PUMP_FORCED: assert property (@(posedge clk) disable iff (rst)
    mode_3w |=> pump_hi); // R8
  AST_SW1_LOCK: assert property (@(posedge clk) disable iff (rst)
    mode_3w |=> (sw1_on == $past(lock_in))); // R9
endmodule

// File: tb/test_tw_loader_top.sv
module test_tw_loader_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int SYNC = 2;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_3w = 1'b1, ser_dat = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
  logic lock_in = 1'b0, alt_pump_hi = 1'b0, alt_sw1 = 1'b0;
  logic [14:0] scale_q;
  logic [3:0] port_q;
  logic pump_hi, sw1_on;

  int n_vec = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_loader_top i_tw_loader_top (
    .clk(clk), .rst(rst), .mode_3w(mode_3w), .ser_dat(ser_dat),
    .ser_clk(ser_clk), .ser_en(ser_en), .lock_in(lock_in),
    .alt_pump_hi(alt_pump_hi), .alt_sw1(alt_sw1),
    .scale_q(scale_q), .port_q(port_q), .pump_hi(pump_hi), .sw1_on(sw1_on)
  );

  // behavioural reference model: histories of the three lines, integer counter
  logic h_en [0:7], h_ck [0:7], h_dt [0:7];
  int m_cnt = 0, m_word = 0;
  int e_sf = 0, e_port = 0;
  bit e_pump = 0, e_sw1 = 0;

  always @(posedge clk) begin
    bit s_en, p_en, s_ck, p_ck, s_dt;
    cyc++;
    if (rst) begin
      for (int k = 0; k < 8; k++) begin h_en[k] = 0; h_ck[k] = 0; h_dt[k] = 0; end
      m_cnt = 0; m_word = 0; e_sf = 0; e_port = 0; e_pump = 0; e_sw1 = 0;
    end else begin
      s_en = h_en[SYNC-1]; p_en = h_en[SYNC];
      s_ck = h_ck[SYNC-1]; p_ck = h_ck[SYNC];
      s_dt = h_dt[SYNC-1];
      if (mode_3w && !s_en && p_en && m_cnt == 19) begin
        e_port = (m_word >> 15) & 15;
        e_sf   = m_word & 32'h7fff;
      end
      if (!mode_3w) m_cnt = 0;
      else if (s_en && !p_en) m_cnt = 0;
      else if (s_en && !s_ck && p_ck) begin
        m_word = ((m_word << 1) | int'(s_dt)) & 32'h7ffff;
        if (m_cnt < 20) m_cnt++;
      end
      e_pump = mode_3w ? 1'b1 : alt_pump_hi;
      e_sw1  = mode_3w ? lock_in : alt_sw1;
      for (int k = 7; k > 0; k--) begin h_en[k] = h_en[k-1]; h_ck[k] = h_ck[k-1]; h_dt[k] = h_dt[k-1]; end
    end
    h_en[0] = ser_en; h_ck[0] = ser_clk; h_dt[0] = ser_dat;
    if (cyc >= LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // every-clock comparison against the model (R11 timing is checked here)
  always @(negedge clk) begin
    if (!rst) begin
      n_vec++;
      if (int'(scale_q) != e_sf || int'(port_q) != e_port ||
          pump_hi != e_pump || sw1_on != e_sw1) begin
        n_bad++;
        $display("FAIL %s/R11 cyc %0d: sf=%h port=%h pump=%b sw1=%b exp sf=%h port=%h pump=%b sw1=%b",
                 cur_req, cyc, scale_q, port_q, pump_hi, sw1_on, e_sf, e_port, e_pump, e_sw1);
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sck_pulse(bit b);
    ser_dat = b;
    wait_clk(HALF); ser_clk = 1'b1;
    wait_clk(HALF); ser_clk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send(logic [31:0] w, int nbits);
    ser_en = 1'b1; wait_clk(3*HALF);
    for (int i = 0; i < nbits; i++) sck_pulse(w[nbits-1-i]);
    ser_en = 1'b0; wait_clk(4*HALF);
  endtask

  initial begin
    wait_clk(4);
    chk("R1 scale", int'(scale_q), 0);
    chk("R1 port", int'(port_q), 0);
    chk("R1 pins", int'({pump_hi, sw1_on}), 0);
    rst = 1'b0;
    wait_clk(4);

    cur_req = "R2";
    send({13'd0, 4'hA, 15'h1234}, 19);
    chk("R2 port word A", int'(port_q), 'hA);
    chk("R2 sf word A", int'(scale_q), 'h1234);
    send({13'd0, 4'h3, 15'h4C01}, 19);
    chk("R2 port word B", int'(port_q), 'h3);
    chk("R2 sf word B", int'(scale_q), 'h4C01);

    // R11: exact latency of a valid load
    cur_req = "R11";
    ser_en = 1'b1; wait_clk(3*HALF);
    for (int i = 0; i < 19; i++) sck_pulse(i < 4 ? 1'b0 : 1'b1);
    ser_en = 1'b0;
    wait_clk(SYNC);
    chk("R11 not yet loaded", int'(scale_q), 'h4C01);
    wait_clk(1);
    chk("R11 loaded", int'(scale_q), 'h7FFF);
    chk("R11 port", int'(port_q), 0);
    wait_clk(4*HALF);

    cur_req = "R4";
    send({14'd0, 18'h2AAAA}, 18);
    chk("R4 18 edges rejected sf, R6 hold", int'(scale_q), 'h7FFF);
    cur_req = "R5";
    send({12'd0, 20'hFFFFF}, 20);
    chk("R5 20 edges rejected, R6 hold", int'(scale_q), 'h7FFF);
    send(32'h1FFFFFF, 25);
    chk("R5 25 edges rejected port, R6 hold", int'(port_q), 0);

    cur_req = "R3";
    ser_en = 1'b0;
    for (int i = 0; i < 5; i++) sck_pulse(1'b1);
    wait_clk(4*HALF);
    send({13'd0, 4'h5, 15'h0F0F}, 19);
    chk("R3 low-enable clocks ignored sf", int'(scale_q), 'h0F0F);
    chk("R3 port", int'(port_q), 'h5);

    cur_req = "R7";
    send({22'd0, 10'h3FF}, 10);
    chk("R7 short burst rejected", int'(scale_q), 'h0F0F);
    send({13'd0, 4'hC, 15'h2468}, 19);
    chk("R7 count cleared at enable rise", int'(scale_q), 'h2468);

    cur_req = "R10";
    mode_3w = 1'b0; wait_clk(2);
    send({13'd0, 4'hF, 15'h7777}, 19);
    chk("R10 off-mode word ignored sf", int'(scale_q), 'h2468);
    chk("R10 port", int'(port_q), 'hC);

    cur_req = "R8/R9";
    alt_pump_hi = 1'b0; alt_sw1 = 1'b1; lock_in = 1'b1; wait_clk(2);
    chk("R8 pump follows alt", int'(pump_hi), 0);
    chk("R9 sw1 follows alt", int'(sw1_on), 1);
    alt_pump_hi = 1'b1; alt_sw1 = 1'b0; wait_clk(2);
    chk("R8 pump follows alt high", int'(pump_hi), 1);
    chk("R9 sw1 follows alt low", int'(sw1_on), 0);
    mode_3w = 1'b1; alt_pump_hi = 1'b0; lock_in = 1'b0; wait_clk(2);
    chk("R8 pump forced", int'(pump_hi), 1);
    chk("R9 sw1 = lock low", int'(sw1_on), 0);
    lock_in = 1'b1; wait_clk(2);
    chk("R9 sw1 = lock high", int'(sw1_on), 1);

    cur_req = "R1";
    rst = 1'b1; wait_clk(2);
    chk("R1 reset again sf", int'(scale_q), 0);
    rst = 1'b0; wait_clk(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule